// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Controller

This block gathers single-cycle event pulses from seventeen sources of an Ethernet MAC (receive frame errors, receive and transmit FIFO and ECC faults, link faults, and two management-interface events) into a sticky event register. Each event bit stays set until software writes a one to it. Writing a zero to an event bit leaves it alone, so a single all-ones write clears everything that is pending.

A mask register of the same width selects which latched events may raise an interrupt. Two level interrupt outputs come out of the block. One is the error interrupt for the fifteen frame, FIFO, ECC and fault sources. The other is a management interrupt for the command-complete and scan events. Software reaches both registers through a plain single-cycle port with write enable, read enable, address and 32-bit data. Read data is registered and appears one cycle after the read strobe.

Top module: `mac_irq_ctrl`

## Requirements
- R1: A one on `evt_pulse[i]` in a cycle sets event bit i at that clock edge. The fixed bit map is: 0 alignment error, 1 CRC error, 2 length error, 3 fragment, 4 runt, 5 oversize, 6 jabber, 7 receive ECC, 8 receive FIFO overflow, 9 transmit error, 10 transmit FIFO overflow, 11 transmit FIFO underflow, 12 transmit ECC, 13 local fault, 14 remote fault, 15 management command complete, 16 management scan.
- R2: An event bit stays set once the pulse has ended, until a clearing write hits it.
- R3: A write to the event address (1) clears each event bit whose data bit is one and leaves each bit whose data bit is zero unchanged. An all-ones write clears every pending event.
- R4: When a source pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to the mask address (0) loads mask bits 16..0 from the write data. The mask holds its value when no such write occurs.
- R6: `err_irq` is high exactly when some bit in 0..14 is set in both the event register and the mask register.
- R7: `mdio_irq` is high exactly when bit 15 or bit 16 is set in both registers. Bits 15 and 16 never affect `err_irq`.
- R8: Events latch while masked and raise no interrupt. Setting the mask bit of a pending event raises the matching interrupt in the cycle right after the mask write.
- R9: Bits 31..17 of both registers read as zero, and writes to them have no effect.
- R10: Reset clears every event bit and every mask bit, and drives both interrupts low.
- R11: A read returns its data on `reg_rd_data` one cycle after `reg_rd_en`, and the value holds until the next read. An address other than 0 or 1 reads as zero, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 17 | Single-cycle event pulses, one per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address: 0 mask, 1 event |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Registered read data |
| err_irq | output | 1 | Level interrupt for error events 0..14 |
| mdio_irq | output | 1 | Level interrupt for management events 15..16 |

## Verification
The assertions watch every cycle for the following:
- every pulsed bit is set after its edge, including when a clear hits it at the same time;
- a clearing write empties the bits it names;
- set bits that are not cleared stay set;
- the mask changes only on a mask write;
- the upper read bits are always zero;
- neither interrupt fires without a matching masked pending bit;
- reset empties both registers.

Only the bench scenarios can show the following:
- the exact bit map for each source;
- the split of the interrupts between the two outputs under many event and mask combinations;
- an interrupt rising right after a mask write on an event already pending;
- that unknown addresses read zero;
- that the read data holds between reads.

// File: rtl/mac_irq_pkg.sv
// Package: shared constants and types for the MAC interrupt event controller.
// Holds the fixed source bit map and the masks that split error events from
// management events. The bit positions are the software-visible layout.
package mac_irq_pkg;

    localparam int NUM_SRC = 17;

    // Source bit positions (software-visible layout)
    localparam int BIT_ALIGN_ERR   = 0;
    localparam int BIT_CRC_ERR     = 1;
    localparam int BIT_LEN_ERR     = 2;
    localparam int BIT_FRAG        = 3;
    localparam int BIT_RUNT        = 4;
    localparam int BIT_OVERSIZE    = 5;
    localparam int BIT_JABBER      = 6;
    localparam int BIT_RX_ECC      = 7;
    localparam int BIT_RX_FIFO_OV  = 8;
    localparam int BIT_TX_ERR      = 9;
    localparam int BIT_TX_FIFO_OV  = 10;
    localparam int BIT_TX_FIFO_UN  = 11;
    localparam int BIT_TX_ECC      = 12;
    localparam int BIT_LOCAL_FLT   = 13;
    localparam int BIT_REMOTE_FLT  = 14;
    localparam int BIT_MGMT_DONE   = 15;
    localparam int BIT_MGMT_SCAN   = 16;

    // First bit of the management group; every bit below it is an error source
    localparam int MGMT_LO = BIT_MGMT_DONE;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    localparam src_vec_t ERR_SEL  = src_vec_t'((32'd1 << MGMT_LO) - 32'd1);
    localparam src_vec_t MGMT_SEL = ~ERR_SEL;

endpackage

// File: rtl/mac_irq_evt_reg.sv
// Module: sticky event register.
// Each bit sets on its source pulse and clears on a one in the clear vector.
// A set wins over a clear in the same cycle, so no event is ever lost.
// Assumes the clear vector is already qualified by write enable and address.
module mac_irq_evt_reg
    import mac_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    output src_vec_t evt_o
);

    src_vec_t evt_q;

    // Update the sticky bits: clear first, then merge the new pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_i) | set_i;
        end
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/mac_irq_mask_reg.sv
// Module: interrupt mask register.
// It loads all source bits on a qualified write and holds them otherwise.
// Assumes the data is already cut to the source width.
module mac_irq_mask_reg
    import mac_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  src_vec_t data_i,
    output src_vec_t mask_o
);

    src_vec_t mask_q;

    // Load on write and hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= data_i;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/mac_irq_combine.sv
// Module: interrupt combiner.
// It gates each event bit with its mask bit. It then reduces the error group
// and the management group to two level outputs. It is purely combinational,
// so an output follows its register inputs in the same cycle.
module mac_irq_combine
    import mac_irq_pkg::*;
(
    input  src_vec_t evt_i,
    input  src_vec_t mask_i,
    output logic     err_irq_o,
    output logic     mgmt_irq_o
);

    src_vec_t pend;

    // Gate each source with its own mask bit
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        assign pend[i] = evt_i[i] & mask_i[i];
    end

    // Reduce each group to one level interrupt
    always_comb begin
        err_irq_o  = |(pend & ERR_SEL);
        mgmt_irq_o = |(pend & MGMT_SEL);
    end

endmodule

// File: rtl/mac_irq_regif.sv
// Module: register access port.
// It decodes single-cycle writes into a write-one-to-clear vector for the
// events and a load strobe for the mask. Reads are registered and return one
// cycle after the strobe; unknown addresses read zero. Upper data bits above
// the source width are dropped on write and read back as zero.
module mac_irq_regif
    import mac_irq_pkg::*;
#(
    parameter int                REG_W     = 32,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'd0,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  src_vec_t          evt_i,
    input  src_vec_t          mask_i,
    output src_vec_t          evt_clr_o,
    output logic              mask_wr_o,
    output src_vec_t          mask_data_o,
    output logic [REG_W-1:0]  rd_data_o
);

    localparam int PAD_W = REG_W - NUM_SRC;

    logic             hit_mask;
    logic             hit_evt;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rd_q;

    // Decode the address and form the write-side controls
    always_comb begin
        hit_mask    = (addr_i == MASK_ADDR);
        hit_evt     = (addr_i == EVT_ADDR);
        mask_wr_o   = wr_en_i && hit_mask;
        mask_data_o = wr_data_i[NUM_SRC-1:0];
        evt_clr_o   = (wr_en_i && hit_evt) ? wr_data_i[NUM_SRC-1:0] : '0;
    end

    // Select the read source and zero-fill the unused upper bits
    always_comb begin
        if (hit_mask) begin
            rd_mux = {{PAD_W{1'b0}}, mask_i};
        end else if (hit_evt) begin
            rd_mux = {{PAD_W{1'b0}}, evt_i};
        end else begin
            rd_mux = '0;
        end
    end

    // Capture read data on the strobe and hold it between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= rd_mux;
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/mac_irq_ctrl.sv
// Module: Ethernet MAC interrupt event controller (top).
// It latches seventeen source pulses into sticky write-one-to-clear event
// bits. A software mask gates them, and two level interrupts come out: one
// for error sources 0..14 and one for management sources 15..16.
// Assumes each source pulse lasts one cycle and that register accesses are
// single-cycle strobes. Reset is synchronous and active low.
module mac_irq_ctrl
    import mac_irq_pkg::*;
#(
    parameter int                REG_W     = 32,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'd0,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [16:0]       evt_pulse,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    output logic [REG_W-1:0]  reg_rd_data,
    output logic              err_irq,
    output logic              mdio_irq
);

    src_vec_t evt_q;
    src_vec_t mask_q;
    src_vec_t evt_clr;
    src_vec_t mask_data;
    logic     mask_wr;

    mac_irq_regif #(
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .MASK_ADDR(MASK_ADDR),
        .EVT_ADDR (EVT_ADDR)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .rd_en_i    (reg_rd_en),
        .addr_i     (reg_addr),
        .wr_data_i  (reg_wr_data),
        .evt_i      (evt_q),
        .mask_i     (mask_q),
        .evt_clr_o  (evt_clr),
        .mask_wr_o  (mask_wr),
        .mask_data_o(mask_data),
        .rd_data_o  (reg_rd_data)
    );

    mac_irq_evt_reg u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(evt_pulse),
        .clr_i(evt_clr),
        .evt_o(evt_q)
    );

    mac_irq_mask_reg u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (mask_wr),
        .data_i(mask_data),
        .mask_o(mask_q)
    );

    mac_irq_combine u_comb (
        .evt_i     (evt_q),
        .mask_i    (mask_q),
        .err_irq_o (err_irq),
        .mgmt_irq_o(mdio_irq)
    );

endmodule

// File: rtl/mac_irq_ctrl_chk.sv
// Module: assertion checker for mac_irq_ctrl, attached by bind.
// It observes the top-level ports and the two state registers and checks the
// set, clear, hold, gating and reset rules on every cycle.
module mac_irq_ctrl_chk
    import mac_irq_pkg::*;
#(
    parameter int                REG_W     = 32,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'd0,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [16:0]       evt_pulse,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wr_data,
    input logic [REG_W-1:0]  reg_rd_data,
    input src_vec_t          evt_q,
    input src_vec_t          mask_q,
    input logic              err_irq,
    input logic              mdio_irq
);

    src_vec_t chk_clr;
    logic     chk_mask_wr;

    // Independent view of the write-side intent
    always_comb begin
        chk_clr     = (reg_wr_en && reg_addr == EVT_ADDR) ? reg_wr_data[NUM_SRC-1:0] : '0;
        chk_mask_wr = reg_wr_en && reg_addr == MASK_ADDR;
    end

    // R1 and R4: every pulsed bit is set after the edge, even under a clear
    p_pulse_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: bits that a clearing write names, and no pulse sets, are zero after the edge
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && chk_clr != '0) |=> ((evt_q & $past(chk_clr & ~evt_pulse)) == '0));

    // R2: set bits that are not cleared stay set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(evt_q) & ~$past(chk_clr) & ~evt_q) == '0));

    // R5: the mask moves only on a mask write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !chk_mask_wr) |=> $stable(mask_q));

    // R6: no error interrupt without a masked pending error bit
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & mask_q & ERR_SEL) == '0) |-> !err_irq);

    // R7: no management interrupt without a masked pending management bit
    p_mdio_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & mask_q & MGMT_SEL) == '0) |-> !mdio_irq);

    // R8: a fully masked controller raises nothing
    p_masked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!err_irq && !mdio_irq));

    // R9: upper read bits are always zero
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[REG_W-1:NUM_SRC] == '0);

    // R10: reset empties both registers
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (evt_q == '0 && mask_q == '0));

endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .MASK_ADDR(MASK_ADDR),
    .EVT_ADDR (EVT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .err_irq    (err_irq),
    .mdio_irq   (mdio_irq)
);

// File: tb/mac_irq_ctrl_tb.sv
// Bench for mac_irq_ctrl. It drives inputs on the falling edge and samples
// outputs on the next falling edge. Expected values are computed
// arithmetically from the requirements.
module mac_irq_ctrl_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [3:0]  A_MASK     = 4'd0;
    localparam logic [3:0]  A_EVT      = 4'd1;
    localparam logic [3:0]  A_BAD      = 4'd7;
    localparam logic [16:0] ERR_BITS   = 17'h07FFF;
    localparam logic [16:0] MGMT_BITS  = 17'h18000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] evt_pulse = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        err_irq;
    logic        mdio_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_pulse  (evt_pulse),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data),
        .err_irq    (err_irq),
        .mdio_irq   (mdio_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_addr    = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rd_data;
    endtask

    task automatic do_pulse(input logic [16:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] rd;
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        check("R10 err_irq after reset", {31'd0, err_irq}, 32'd0);
        check("R10 mdio_irq after reset", {31'd0, mdio_irq}, 32'd0);
        do_read(A_EVT, rd);  check("R10 event after reset", rd, 32'd0);
        do_read(A_MASK, rd); check("R10 mask after reset", rd, 32'd0);

        // Per-source sweep: R1 map, R8 masked latch/unmask, R6/R7 split, R3 clear
        for (int i = 0; i < 17; i++) begin
            logic [16:0] b;
            b = 17'd1 << i;
            do_pulse(b);
            do_read(A_EVT, rd);
            check("R1 source bit position", rd, {15'd0, b});
            check("R8 masked event gives no irq", {30'd0, err_irq, mdio_irq}, 32'd0);
            repeat (3) @(negedge clk);
            do_read(A_EVT, rd);
            check("R2 event held after idle", rd, {15'd0, b});
            do_write(A_MASK, {15'd0, b});
            check("R8 R6 err_irq on unmask", {31'd0, err_irq}, {31'd0, (i < 15)});
            check("R8 R7 mdio_irq on unmask", {31'd0, mdio_irq}, {31'd0, (i >= 15)});
            do_write(A_EVT, 32'd0);
            do_read(A_EVT, rd);
            check("R3 zero write keeps event", rd, {15'd0, b});
            do_write(A_EVT, {15'd0, b});
            check("R3 clear drops irq", {30'd0, err_irq, mdio_irq}, 32'd0);
            do_read(A_EVT, rd);
            check("R3 one write clears event", rd, 32'd0);
            do_write(A_MASK, 32'd0);
        end

        // Pattern sweep over event/mask combinations: R5, R6, R7, R3 all-ones clear
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 64; k++) begin
            logic [16:0] e;
            logic [16:0] m;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            e = lf[16:0];
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            m = lf[16:0];
            do_write(A_EVT, 32'hFFFF_FFFF);
            do_write(A_MASK, {15'd0, m});
            do_pulse(e);
            check("R6 err_irq pattern", {31'd0, err_irq}, {31'd0, |(e & m & ERR_BITS)});
            check("R7 mdio_irq pattern", {31'd0, mdio_irq}, {31'd0, |(e & m & MGMT_BITS)});
            do_read(A_MASK, rd); check("R5 mask readback", rd, {15'd0, m});
            do_read(A_EVT, rd);  check("R1 event pattern", rd, {15'd0, e});
        end
        do_write(A_EVT, 32'hFFFF_FFFF);
        do_read(A_EVT, rd); check("R3 all-ones clears all", rd, 32'd0);
        do_write(A_MASK, 32'd0);

        // R4: set and clear on the same bit in the same cycle
        do_pulse(17'h00020);
        @(negedge clk);
        evt_pulse   = 17'h00008;
        reg_wr_en   = 1'b1;
        reg_addr    = A_EVT;
        reg_wr_data = 32'h0000_0028;
        @(negedge clk);
        evt_pulse   = '0;
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
        do_read(A_EVT, rd); check("R4 set wins over clear", rd, 32'h0000_0008);

        // R9: upper bits read zero and ignore writes
        do_write(A_MASK, 32'hFFFF_FFFF);
        do_read(A_MASK, rd); check("R9 mask upper bits zero", rd, 32'h0001_FFFF);
        do_pulse(17'h1FFFF);
        do_write(A_EVT, 32'hFFFE_0000);
        do_read(A_EVT, rd); check("R9 event upper write ignored", rd, 32'h0001_FFFF);

        // R11: unknown address reads zero and writes there change nothing
        do_write(A_BAD, 32'hFFFF_FFFF);
        do_read(A_BAD, rd);  check("R11 unknown address reads zero", rd, 32'd0);
        do_read(A_EVT, rd);  check("R11 stray write keeps events", rd, 32'h0001_FFFF);
        do_read(A_MASK, rd); check("R11 stray write keeps mask", rd, 32'h0001_FFFF);
        @(negedge clk);
        reg_addr = A_BAD;
        repeat (3) @(negedge clk);
        check("R11 read data holds between reads", reg_rd_data, 32'h0001_FFFF);
        check("R6 all sources raise err_irq", {31'd0, err_irq}, 32'd1);
        check("R7 all sources raise mdio_irq", {31'd0, mdio_irq}, 32'd1);

        // R10: reset in mid-run clears both registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 irq low after reset", {30'd0, err_irq, mdio_irq}, 32'd0);
        do_read(A_EVT, rd);  check("R10 events cleared by reset", rd, 32'd0);
        do_read(A_MASK, rd); check("R10 mask cleared by reset", rd, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule